// File: doc/BRIEF.md
# Anode Cathode Coincidence Matcher

This block takes up to two anode candidates and up to two cathode candidates in each clock and builds two combined muon words from them. The anode side is produced earlier than the cathode side, so the two anode candidates first pass through a delay line whose length can be set from 1 to 10 clocks. The aligned anode pair is then combined with the cathode pair presented in the same clock.

The pairing follows a few rules. Two of each are paired by rank. A single candidate of one kind facing two of the other is copied into both muons. A lone kind is passed through with the missing half zeroed. Each muon carries a 2-bit code that says how far the anode crossing tag is from the cathode tag. A shared 2-bit status code classifies the pattern of the four valid flags, so that a downstream trigger can judge how far to trust the pairing.

Top module: `acm_matcher`

## Requirements
- R1: While `rst_n` is low, `muon1`, `muon2` and `status` are zero and the anode delay line is cleared, so an anode captured before a reset never pairs with a cathode after it.
- R2: Anode word layout: [15] valid, [14:10] crossing tag, [9:3] position, [2] accelerator flag, [1:0] quality. Cathode word layout: [22] valid, [21:17] crossing tag, [16:9] half-strip, [8] bend, [7:0] pattern. An anode pair sampled at edge E is combined with the cathode pair sampled at edge E+D, and the results appear after edge E+D. D is `delaySel`, where 0 is treated as 1 and values above 10 are treated as 10.
- R3: `status` is 2'b00 when all four valid flags are clear.
- R4: `status` is 2'b11 when exactly anode1 and cathode1 are valid, or when all four are valid.
- R5: `status` is 2'b01 when exactly anode1, anode2 and cathode1 are valid, or exactly anode1, cathode1 and cathode2.
- R6: `status` is 2'b10 for every other non-empty flag pattern.
- R7: The muon match field is computed from d = (anode tag - cathode tag) mod 32. It is 2'b00 for d=0, 2'b01 for d=+1, 2'b10 for d=-1 (31), and 2'b11 otherwise. A tag wrap from 31 to 0 therefore counts as a difference of 1.
- R8: Muon word layout: [34] valid, [33:32] match, [31:27] crossing tag, [26:20] position, [19] accelerator, [18:17] quality, [16:9] half-strip, [8] bend, [7:0] pattern. The muon crossing tag is the anode tag, and the cathode tag is not output.
- R9: Valid candidates of each kind are taken in slot order, first valid slot first. With two of one kind and one of the other, the single candidate's fields appear in both muons.
- R10: With all four valid, muon1 pairs anode1 with cathode1 and muon2 pairs anode2 with cathode2.
- R11: When only one kind is valid, its candidates are still output with the other half's fields and the match field zero. A muon with no candidate is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| delaySel | input | 4 | Anode delay in clocks (1 to 10, clamped) |
| anode1 | input | 16 | Best anode candidate |
| anode2 | input | 16 | Second anode candidate |
| cathode1 | input | 23 | Best cathode candidate |
| cathode2 | input | 23 | Second cathode candidate |
| muon1 | output | 35 | First combined muon word |
| muon2 | output | 35 | Second combined muon word |
| status | output | 2 | Flag-pattern class |

## Verification
The assertions assume that `delaySel` changes only while the delay line holds no valid anode. They also assume that a candidate whose valid bit is clear carries zero in its other fields, because a muon half that is absent is compared against zero. The stimulus drives every idle candidate as an all-zero word. It changes `delaySel` only between transfers, after the previous anode pair has left the line. Each transfer is a single anode pulse followed by a single cathode pulse, so only one aligned pair is ever in flight.

// File: rtl/acm_pkg.sv
package acm_pkg;

  localparam int BX_W    = 5;
  localparam int NUM_CAN = 2;
  localparam int NUM_MU  = 2;

  typedef struct packed {
    logic            valid;
    logic [BX_W-1:0] bx;
    logic [6:0]      gang;
    logic            accel;
    logic [1:0]      quality;
  } anode_t;

  typedef struct packed {
    logic            valid;
    logic [BX_W-1:0] bx;
    logic [7:0]      strip;
    logic            bend;
    logic [7:0]      pattern;
  } cathode_t;

  typedef struct packed {
    logic            valid;
    logic [1:0]      match;
    logic [BX_W-1:0] bx;
    logic [6:0]      gang;
    logic            accel;
    logic [1:0]      quality;
    logic [7:0]      strip;
    logic            bend;
    logic [7:0]      pattern;
  } muon_t;

  // per-muon selection strobes from control to datapath
  typedef struct packed {
    logic aEn;
    logic aSel;
    logic cEn;
    logic cSel;
  } pick_t;

  typedef pick_t [NUM_MU-1:0] strobe_t;

  typedef enum logic [1:0] {
    ST_NONE   = 2'b00,
    ST_DOUBLE = 2'b01,
    ST_AMBIG  = 2'b10,
    ST_CLEAN  = 2'b11
  } status_e;

  function automatic logic [1:0] bxMatch(input logic [BX_W-1:0] aBx,
                                         input logic [BX_W-1:0] cBx);
    logic [BX_W-1:0] diff;
    diff = aBx - cBx;
    if (diff == '0)                bxMatch = 2'b00;
    else if (diff == BX_W'(1))     bxMatch = 2'b01;
    else if (diff == {BX_W{1'b1}}) bxMatch = 2'b10;
    else                           bxMatch = 2'b11;
  endfunction

endpackage

// File: rtl/acm_ctrl.sv
module acm_ctrl
  import acm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CAN-1:0] aValid,
  input  logic [NUM_CAN-1:0] cValid,
  output strobe_t            strobes,
  output logic [1:0]         status
);

  logic    anyA, anyC, twoA, twoC;
  status_e statusNext;

  assign anyA = |aValid;
  assign anyC = |cValid;
  assign twoA = &aValid;
  assign twoC = &cValid;

  always_comb begin
    // first muon takes the first valid slot of each kind
    strobes[0].aEn  = anyA;
    strobes[0].aSel = ~aValid[0];
    strobes[0].cEn  = anyC;
    strobes[0].cSel = ~cValid[0];
    // second muon: second slot if two, otherwise duplicate when other side has two
    strobes[1].aEn  = twoA | (anyA & twoC);
    strobes[1].aSel = twoA ? 1'b1 : ~aValid[0];
    strobes[1].cEn  = twoC | (anyC & twoA);
    strobes[1].cSel = twoC ? 1'b1 : ~cValid[0];
  end

  always_comb begin
    case ({cValid, aValid})
      4'b0000:          statusNext = ST_NONE;
      4'b0101, 4'b1111: statusNext = ST_CLEAN;
      4'b0111, 4'b1101: statusNext = ST_DOUBLE;
      default:          statusNext = ST_AMBIG;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= 2'b00;
    else        status <= statusNext;
  end

  assert_idle_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (aValid == '0 && cValid == '0) |=> (status == 2'b00));

  assert_second_needs_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes[1].aEn |-> strobes[0].aEn) and (strobes[1].cEn |-> strobes[0].cEn));

  assert_lone_kind_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!anyA) |=> (status != 2'b11 && status != 2'b01));

endmodule

// File: rtl/acm_datapath.sv
module acm_datapath
  import acm_pkg::*;
#(
  parameter int MAX_DELAY = 10,
  parameter int SEL_W     = $clog2(MAX_DELAY + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SEL_W-1:0]           delaySel,
  input  anode_t   [NUM_CAN-1:0]     aIn,
  input  cathode_t [NUM_CAN-1:0]     cIn,
  input  strobe_t                    strobes,
  output logic     [NUM_CAN-1:0]     aValidAligned,
  output muon_t    [NUM_MU-1:0]      muOut
);

  localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(MAX_DELAY);
  localparam logic [SEL_W-1:0] ONE_SEL = SEL_W'(1);

  anode_t [NUM_CAN-1:0] stage [MAX_DELAY];
  anode_t [NUM_CAN-1:0] aAligned;
  logic   [SEL_W-1:0]   effDelay;
  logic   [SEL_W-1:0]   tapIdx;

  // delay line: stage k holds the anode pair sampled k+1 edges earlier
  for (genvar g = 0; g < MAX_DELAY; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= aIn;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= '0;
        else        stage[g] <= stage[g-1];
      end
    end
  end

  always_comb begin
    if (delaySel == '0)          effDelay = ONE_SEL;
    else if (delaySel > MAX_SEL) effDelay = MAX_SEL;
    else                         effDelay = delaySel;
    tapIdx = effDelay - ONE_SEL;
  end

  assign aAligned = stage[tapIdx];

  for (genvar c = 0; c < NUM_CAN; c++) begin : g_flag
    assign aValidAligned[c] = aAligned[c].valid;
  end

  for (genvar m = 0; m < NUM_MU; m++) begin : g_mu
    anode_t   aPick;
    cathode_t cPick;
    muon_t    muNext;
    muon_t    muReg;

    always_comb begin
      aPick = strobes[m].aEn ? aAligned[strobes[m].aSel] : '0;
      cPick = strobes[m].cEn ? cIn[strobes[m].cSel]      : '0;
      muNext         = '0;
      muNext.valid   = strobes[m].aEn | strobes[m].cEn;
      muNext.match   = (strobes[m].aEn && strobes[m].cEn) ? bxMatch(aPick.bx, cPick.bx) : 2'b00;
      muNext.bx      = aPick.bx;
      muNext.gang    = aPick.gang;
      muNext.accel   = aPick.accel;
      muNext.quality = aPick.quality;
      muNext.strip   = cPick.strip;
      muNext.bend    = cPick.bend;
      muNext.pattern = cPick.pattern;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) muReg <= '0;
      else        muReg <= muNext;
    end

    assign muOut[m] = muReg;

    assert_half_no_match_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (strobes[m].aEn != strobes[m].cEn) |=> (muReg.match == 2'b00));

    assert_empty_is_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!muReg.valid) |-> (muReg == '0));
  end

  assert_tap_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tapIdx < MAX_SEL);

endmodule

// File: rtl/acm_matcher.sv
module acm_matcher
  import acm_pkg::*;
#(
  parameter  int MAX_DELAY = 10,
  localparam int SEL_W     = $clog2(MAX_DELAY + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [SEL_W-1:0]           delaySel,
  input  logic [$bits(anode_t)-1:0]  anode1,
  input  logic [$bits(anode_t)-1:0]  anode2,
  input  logic [$bits(cathode_t)-1:0] cathode1,
  input  logic [$bits(cathode_t)-1:0] cathode2,
  output logic [$bits(muon_t)-1:0]   muon1,
  output logic [$bits(muon_t)-1:0]   muon2,
  output logic [1:0]                 status
);

  anode_t   [NUM_CAN-1:0] aIn;
  cathode_t [NUM_CAN-1:0] cIn;
  muon_t    [NUM_MU-1:0]  muOut;
  logic     [NUM_CAN-1:0] aValidAligned;
  logic     [NUM_CAN-1:0] cValid;
  strobe_t                strobes;

  assign aIn[0] = anode_t'(anode1);
  assign aIn[1] = anode_t'(anode2);
  assign cIn[0] = cathode_t'(cathode1);
  assign cIn[1] = cathode_t'(cathode2);
  assign cValid = {cIn[1].valid, cIn[0].valid};

  acm_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .aValid  (aValidAligned),
    .cValid  (cValid),
    .strobes (strobes),
    .status  (status)
  );

  acm_datapath #(
    .MAX_DELAY (MAX_DELAY),
    .SEL_W     (SEL_W)
  ) u_dp (
    .clk           (clk),
    .rst_n         (rst_n),
    .delaySel      (delaySel),
    .aIn           (aIn),
    .cIn           (cIn),
    .strobes       (strobes),
    .aValidAligned (aValidAligned),
    .muOut         (muOut)
  );

  assign muon1 = muOut[0];
  assign muon2 = muOut[1];

  assert_clean_has_muon_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b11) |-> muon1[$bits(muon_t)-1]);

  assert_double_shares_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b01) |-> (muon1[$bits(muon_t)-1] && muon2[$bits(muon_t)-1] &&
                           ((muon1[16:0] == muon2[16:0]) || (muon1[31:17] == muon2[31:17]))));

  assert_none_means_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b00) |-> (muon1 == '0 && muon2 == '0));

  assert_second_implies_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    muon2[$bits(muon_t)-1] |-> muon1[$bits(muon_t)-1]);

endmodule

// File: tb/acm_matcher_test.sv
`timescale 1ns/1ps
module acm_matcher_test;
  import acm_pkg::*;

  logic     clk = 1'b0;
  logic     rst_n;
  logic [3:0] delaySel;
  anode_t   anode1, anode2;
  cathode_t cathode1, cathode2;
  muon_t    muon1, muon2;
  logic [1:0] status;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  acm_matcher uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .delaySel (delaySel),
    .anode1   (anode1),
    .anode2   (anode2),
    .cathode1 (cathode1),
    .cathode2 (cathode2),
    .muon1    (muon1),
    .muon2    (muon2),
    .status   (status)
  );

  // {flags c2 c1 a2 a1, a1 tag, a2 tag, c1 tag, c2 tag, expected status}
  localparam int NV = 18;
  localparam logic [25:0] VEC [NV] = '{
    {4'b0000, 5'd0,  5'd0,  5'd0,  5'd0,  2'b00},
    {4'b0001, 5'd4,  5'd0,  5'd0,  5'd0,  2'b10},
    {4'b0010, 5'd0,  5'd6,  5'd0,  5'd0,  2'b10},
    {4'b0011, 5'd2,  5'd3,  5'd0,  5'd0,  2'b10},
    {4'b0100, 5'd0,  5'd0,  5'd8,  5'd0,  2'b10},
    {4'b0101, 5'd7,  5'd0,  5'd7,  5'd0,  2'b11},
    {4'b0110, 5'd0,  5'd10, 5'd11, 5'd0,  2'b10},
    {4'b0111, 5'd9,  5'd12, 5'd8,  5'd0,  2'b01},
    {4'b1000, 5'd0,  5'd0,  5'd0,  5'd5,  2'b10},
    {4'b1001, 5'd15, 5'd0,  5'd0,  5'd13, 2'b10},
    {4'b1010, 5'd0,  5'd1,  5'd0,  5'd1,  2'b10},
    {4'b1011, 5'd3,  5'd4,  5'd0,  5'd4,  2'b10},
    {4'b1100, 5'd0,  5'd0,  5'd20, 5'd21, 2'b10},
    {4'b1101, 5'd0,  5'd0,  5'd1,  5'd31, 2'b01},
    {4'b1110, 5'd0,  5'd16, 5'd17, 5'd15, 2'b10},
    {4'b1111, 5'd31, 5'd0,  5'd0,  5'd31, 2'b11},
    {4'b0101, 5'd20, 5'd0,  5'd25, 5'd0,  2'b11},
    {4'b0101, 5'd0,  5'd0,  5'd31, 5'd0,  2'b11}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic anode_t mkA(input bit v, input logic [4:0] bx, input int seed);
    anode_t a = '0;
    if (v) begin
      a.valid = 1'b1; a.bx = bx; a.gang = 7'(seed * 5 + 3);
      a.accel = seed[0]; a.quality = 2'(seed + 1);
    end
    return a;
  endfunction

  function automatic cathode_t mkC(input bit v, input logic [4:0] bx, input int seed);
    cathode_t c = '0;
    if (v) begin
      c.valid = 1'b1; c.bx = bx; c.strip = 8'(seed * 9 + 2);
      c.bend = seed[1]; c.pattern = 8'(seed * 17 + 1);
    end
    return c;
  endfunction

  function automatic logic [1:0] expMatch(input logic [4:0] a, input logic [4:0] c);
    int d = (int'(a) - int'(c) + 32) % 32;
    if (d == 0)       return 2'b00;
    else if (d == 1)  return 2'b01;
    else if (d == 31) return 2'b10;
    else              return 2'b11;
  endfunction

  // reference model of the pairing rules, written from the requirements
  function automatic muon_t model(input int slot, input anode_t a1, input anode_t a2,
                                  input cathode_t c1, input cathode_t c2);
    anode_t   aL [2];
    cathode_t cL [2];
    int na = 0, nc = 0;
    bit hasA = 0, hasC = 0;
    anode_t   a = '0;
    cathode_t c = '0;
    muon_t    r = '0;
    aL[0] = '0; aL[1] = '0; cL[0] = '0; cL[1] = '0;
    if (a1.valid) begin aL[na] = a1; na++; end
    if (a2.valid) begin aL[na] = a2; na++; end
    if (c1.valid) begin cL[nc] = c1; nc++; end
    if (c2.valid) begin cL[nc] = c2; nc++; end
    if (slot == 0) begin
      hasA = (na > 0); a = aL[0];
      hasC = (nc > 0); c = cL[0];
    end else begin
      if (na == 2)                begin hasA = 1; a = aL[1]; end
      else if (na == 1 && nc == 2) begin hasA = 1; a = aL[0]; end
      if (nc == 2)                begin hasC = 1; c = cL[1]; end
      else if (nc == 1 && na == 2) begin hasC = 1; c = cL[0]; end
    end
    if (hasA || hasC) begin
      r.valid = 1'b1;
      if (hasA) begin r.bx = a.bx; r.gang = a.gang; r.accel = a.accel; r.quality = a.quality; end
      if (hasC) begin r.strip = c.strip; r.bend = c.bend; r.pattern = c.pattern; end
      if (hasA && hasC) r.match = expMatch(a.bx, c.bx);
    end
    return r;
  endfunction

  function automatic string statusTag(input logic [1:0] s);
    case (s)
      2'b00:   return "R3";
      2'b11:   return "R4";
      2'b01:   return "R5";
      default: return "R6";
    endcase
  endfunction

  // anode pair at one edge, cathode pair 'ahead' edges later, check after that edge
  task automatic runVec(input anode_t a1, input anode_t a2, input cathode_t c1,
                        input cathode_t c2, input int ahead, input logic [1:0] expSt,
                        input string label);
    muon_t e1, e2;
    int na, nc;
    string mTag;
    @(negedge clk);
    anode1 = a1; anode2 = a2; cathode1 = '0; cathode2 = '0;
    @(negedge clk);
    anode1 = '0; anode2 = '0;
    repeat (ahead - 1) @(negedge clk);
    cathode1 = c1; cathode2 = c2;
    @(negedge clk);
    e1 = model(0, a1, a2, c1, c2);
    e2 = model(1, a1, a2, c1, c2);
    na = int'(a1.valid) + int'(a2.valid);
    nc = int'(c1.valid) + int'(c2.valid);
    if (ahead < 0) begin na = 0; end
    if (na == 2 && nc == 2)      mTag = "R10";
    else if (na + nc == 3)       mTag = "R9";
    else if (na == 0 || nc == 0) mTag = "R11";
    else                         mTag = "R7";
    chk(status == expSt, statusTag(expSt), {label, " status"}, 64'(status), 64'(expSt));
    chk(muon1 == e1, mTag, {label, " muon1"}, 64'(muon1), 64'(e1));
    chk(muon2 == e2, mTag, {label, " muon2"}, 64'(muon2), 64'(e2));
    cathode1 = '0; cathode2 = '0;
  endtask

  initial begin
    rst_n = 1'b0;
    delaySel = 4'd1;
    anode1 = '0; anode2 = '0; cathode1 = '0; cathode2 = '0;
    repeat (3) @(negedge clk);
    // R1: outputs cleared in reset
    chk(muon1 == '0 && muon2 == '0 && status == 2'b00, "R1", "reset outputs",
        64'({muon1, status}), 64'(0));
    rst_n = 1'b1;

    // table of flag patterns and tag differences; R2 delay varies per row
    for (int i = 0; i < NV; i++) begin
      logic [25:0] v = VEC[i];
      anode_t   a1 = mkA(v[22], v[21:17], i);
      anode_t   a2 = mkA(v[23], v[16:12], i + 40);
      cathode_t c1 = mkC(v[24], v[11:7], i);
      cathode_t c2 = mkC(v[25], v[6:2], i + 60);
      int d = 1 + (i % 10);
      delaySel = 4'(d);
      runVec(a1, a2, c1, c2, d, v[1:0], $sformatf("R2 row%0d d=%0d", i, d));
      // R8: muon tag is the first valid anode's tag
      if ((v[22] | v[23]) && (v[24] | v[25]))
        chk(muon1.bx == (v[22] ? v[21:17] : v[16:12]), "R8", "muon1 tag",
            64'(muon1.bx), 64'(v[22] ? v[21:17] : v[16:12]));
    end

    // R2: setting 0 behaves as 1
    delaySel = 4'd0;
    runVec(mkA(1, 5'd6, 3), '0, mkC(1, 5'd6, 3), '0, 1, 2'b11, "R2 clamp low");
    // R2: setting 15 behaves as 10
    delaySel = 4'd15;
    runVec(mkA(1, 5'd9, 4), mkA(1, 5'd10, 5), mkC(1, 5'd9, 4), mkC(1, 5'd11, 5), 10, 2'b11,
           "R2 clamp high");

    // R2: misaligned cathode sees no anode
    delaySel = 4'd3;
    begin
      cathode_t c = mkC(1, 5'd2, 7);
      @(negedge clk);
      anode1 = mkA(1, 5'd2, 7); anode2 = '0;
      @(negedge clk);
      anode1 = '0;
      @(negedge clk);
      cathode1 = c;
      @(negedge clk);
      chk(status == 2'b10, "R2", "misaligned status", 64'(status), 64'(2'b10));
      chk(muon1 == model(0, '0, '0, c, '0), "R2", "misaligned muon1",
          64'(muon1), 64'(model(0, '0, '0, c, '0)));
      cathode1 = '0;
      @(negedge clk);
    end

    // R1: reset flushes a pending anode from the delay line
    delaySel = 4'd4;
    begin
      cathode_t c = mkC(1, 5'd12, 9);
      @(negedge clk);
      anode1 = mkA(1, 5'd12, 9);
      @(negedge clk);
      anode1 = '0; rst_n = 1'b0;
      @(negedge clk);
      chk(muon1 == '0 && status == 2'b00, "R1", "mid-run reset", 64'(muon1), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      cathode1 = c;
      @(negedge clk);
      chk(status == 2'b10, "R1", "flushed status", 64'(status), 64'(2'b10));
      chk(muon1 == model(0, '0, '0, c, '0), "R1", "flushed muon1",
          64'(muon1), 64'(model(0, '0, '0, c, '0)));
      cathode1 = '0;
    end

    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule